// File: doc/BRIEF.md
# Fused Logic-Arithmetic Unit for Unofficial Accumulator Opcodes

This is a purely combinational execution slice for an 8-bit accumulator processor. It implements the fused operations that sit outside the documented instruction set. These operations include AND-then-shift, AND-then-rotate with decimal correction, AND-then-subtract, and the "store masked by address high byte" group. The surrounding core decodes the instruction and supplies the register file, the operand fetched from memory, the current carry, decimal, negative, zero and overflow flags, and the high byte of the effective address. It also supplies a flag that says whether indexing carried into that high byte.

In the same cycle the unit returns new values for A, X and S, the byte to be written to memory, a possibly replaced address high byte, and the four arithmetic flags. An operation that does not touch a register or flag passes it through unchanged, so the core can latch every output without condition.

Top module: `combo_op_unit`

## Requirements
- R1: Select 1 (mask-A-X) gives A = (A OR 0xEE) AND operand AND X. N and Z follow the new A. X, S, C and V are unchanged.
- R2: Select 2 (mask-load) writes (A OR 0xEE) AND operand to both A and X. N and Z follow that value, and C and V are unchanged.
- R3: Select 3 (and-carry) gives A = A AND operand. N and Z follow the new A, and C takes bit 7 of the new A.
- R4: Select 4 (and-shift) computes M = A AND operand. C takes M bit 0, and A becomes M shifted right by one with a zero in bit 7. N and Z follow the new A.
- R5: Select 5 (and-rotate) with the decimal input low computes M = A AND operand and R = {C, M[7:1]}. A becomes R, N and Z follow R, V = R[6] XOR R[5], and C = R[6].
- R6: Select 5 with the decimal input high computes N, Z and V from R as in R5. If (M & 0x0F) + M[0] > 5, the low nibble of R gets 6 added, with no carry into the high nibble. If (M & 0xF0) + (M & 0x10) > 0x50, C is set and 0x60 is added modulo 256; otherwise C is cleared.
- R7: Select 6 (and-subtract) gives X = (A AND X) - operand modulo 256, with the carry input ignored. C is set when operand <= (A AND X). N and Z follow the new X, A is unchanged, and V is unchanged.
- R8: Select 7 (stack-mask load) writes S AND operand to A, X and S. N and Z follow that value.
- R9: Selects 8, 9, 10 and 11 without page adjust produce a store byte equal to a source masked with (address high + 1) modulo 256. The sources are A AND X for select 8, X for select 9, Y for select 10, and A AND X for select 11. Select 11 also writes A AND X into S. The address high byte and all flags pass through unchanged.
- R10: With page adjust high, those selects mask with the address high byte itself, and the address high output equals the store byte.
- R11: Select 0 and selects 12 to 15 leave A, X, S, the address high byte and all flags unchanged, and the store byte is 0. Non-store selects also output a store byte of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation select |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index |
| y_in | input | 8 | Y index |
| s_in | input | 8 | Stack pointer |
| operand | input | 8 | Fetched operand byte |
| c_in | input | 1 | Carry flag |
| d_in | input | 1 | Decimal flag |
| n_in | input | 1 | Negative flag |
| z_in | input | 1 | Zero flag |
| v_in | input | 1 | Overflow flag |
| addr_hi | input | 8 | Effective address high byte |
| page_adj | input | 1 | Indexing carried into the high byte |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X |
| s_out | output | 8 | New stack pointer |
| store_data | output | 8 | Byte to write |
| addr_hi_out | output | 8 | Address high byte to use |
| c_out | output | 1 | New carry |
| n_out | output | 1 | New negative |
| z_out | output | 1 | New zero |
| v_out | output | 1 | New overflow |

## Verification
Two pieces of the and-rotate decimal path can act on the same operation. These are the low-nibble +6 fix-up and the high-nibble +0x60 fix-up with its carry. Directed cases such as a mask of 0xFF or 0x5A with either carry value trigger both at once. Random operands with the decimal input toggled cover each alone and neither, and every result is compared with a bench model. The store group is judged the same way: the S write and the address-byte replacement of select 11 fall together under page adjust.

// File: rtl/combo_op_unit.sv
module combo_op_unit #(
  parameter logic [7:0] MAGIC = 8'hEE
) (
  input  logic [3:0] op,
  input  logic [7:0] a_in,
  input  logic [7:0] x_in,
  input  logic [7:0] y_in,
  input  logic [7:0] s_in,
  input  logic [7:0] operand,
  input  logic       c_in,
  input  logic       d_in,
  input  logic       n_in,
  input  logic       z_in,
  input  logic       v_in,
  input  logic [7:0] addr_hi,
  input  logic       page_adj,
  output logic [7:0] a_out,
  output logic [7:0] x_out,
  output logic [7:0] s_out,
  output logic [7:0] store_data,
  output logic [7:0] addr_hi_out,
  output logic       c_out,
  output logic       n_out,
  output logic       z_out,
  output logic       v_out
);
  localparam logic [3:0] OP_MASKAX = 4'd1, OP_MASKLD = 4'd2, OP_ANDC = 4'd3,
                         OP_ANDSH = 4'd4, OP_ANDROT = 4'd5, OP_ANDSUB = 4'd6,
                         OP_STKLD = 4'd7, OP_STAX = 4'd8, OP_STX = 4'd9,
                         OP_STY = 4'd10, OP_STSP = 4'd11;

  wire [7:0] m      = a_in & operand;
  wire [7:0] ax     = a_in & x_in;
  wire [7:0] magic  = (a_in | MAGIC) & operand;
  wire [7:0] rot    = {c_in, m[7:1]};
  wire [8:0] diff   = {1'b0, ax} - {1'b0, operand};
  wire [7:0] lmask  = s_in & operand;
  wire [7:0] hi_m   = page_adj ? addr_hi : addr_hi + 8'd1;
  wire       lo_fix = ({1'b0, m[3:0]} + {4'b0, m[0]}) > 5'd5;
  wire [8:0] hsum   = {1'b0, m & 8'hF0} + {1'b0, m & 8'h10};
  wire       hi_fix = hsum > 9'h050;
  wire [7:0] rot_lo = lo_fix ? {rot[7:4], rot[3:0] + 4'd6} : rot;
  wire [7:0] rot_d  = hi_fix ? rot_lo + 8'h60 : rot_lo;

  logic [7:0] nz_src;
  logic       nz_en;
  logic [7:0] st_src;
  logic       st_en;

  always_comb begin
    a_out  = a_in;
    x_out  = x_in;
    s_out  = s_in;
    c_out  = c_in;
    v_out  = v_in;
    nz_src = 8'h00;
    nz_en  = 1'b0;
    st_src = 8'h00;
    st_en  = 1'b0;
    case (op)
      OP_MASKAX: begin a_out = magic & x_in; nz_src = a_out; nz_en = 1'b1; end
      OP_MASKLD: begin a_out = magic; x_out = magic; nz_src = magic; nz_en = 1'b1; end
      OP_ANDC:   begin a_out = m; c_out = m[7]; nz_src = m; nz_en = 1'b1; end
      OP_ANDSH:  begin a_out = {1'b0, m[7:1]}; c_out = m[0]; nz_src = a_out; nz_en = 1'b1; end
      OP_ANDROT: begin
        nz_src = rot;
        nz_en  = 1'b1;
        v_out  = rot[6] ^ rot[5];
        if (d_in) begin
          a_out = rot_d;
          c_out = hi_fix;
        end else begin
          a_out = rot;
          c_out = rot[6];
        end
      end
      OP_ANDSUB: begin x_out = diff[7:0]; c_out = ~diff[8]; nz_src = diff[7:0]; nz_en = 1'b1; end
      OP_STKLD:  begin a_out = lmask; x_out = lmask; s_out = lmask; nz_src = lmask; nz_en = 1'b1; end
      OP_STAX:   begin st_src = ax;   st_en = 1'b1; end
      OP_STX:    begin st_src = x_in; st_en = 1'b1; end
      OP_STY:    begin st_src = y_in; st_en = 1'b1; end
      OP_STSP:   begin st_src = ax; s_out = ax; st_en = 1'b1; end
      default: ;
    endcase
  end

  assign n_out       = nz_en ? nz_src[7] : n_in;
  assign z_out       = nz_en ? (nz_src == 8'h00) : z_in;
  assign store_data  = st_en ? (st_src & hi_m) : 8'h00;
  assign addr_hi_out = (st_en && page_adj) ? store_data : addr_hi;
endmodule

module combo_op_unit_chk (
  input logic [3:0] op,
  input logic [7:0] a_in, x_in, s_in, operand, addr_hi,
  input logic       c_in, n_in, z_in, v_in, page_adj,
  input logic [7:0] a_out, x_out, s_out, store_data, addr_hi_out,
  input logic       c_out, n_out, z_out, v_out
);
  wire is_store = (op >= 4'd8) && (op <= 4'd11);
  wire is_idle  = (op == 4'd0) || (op >= 4'd12);
  always_comb begin
    if (is_idle)
      assert_idle_hold_R11: assert (a_out == a_in && x_out == x_in && s_out == s_in &&
        c_out == c_in && n_out == n_in && z_out == z_in && v_out == v_in &&
        store_data == 8'h00 && addr_hi_out == addr_hi) else $error("idle changed state");
    if (op == 4'd2)
      assert_mask_load_pair_R2: assert (a_out == x_out) else $error("A and X differ");
    if (op == 4'd7)
      assert_stack_mask_R8: assert (a_out == x_out && x_out == s_out && z_out == (s_out == 8'h00))
        else $error("stack-mask load mismatch");
    if (op == 4'd6)
      assert_sub_inverse_R7: assert (8'(x_out + operand) == (a_in & x_in) && a_out == a_in)
        else $error("subtract not invertible");
    if (op == 4'd4)
      assert_shift_fill_R4: assert (a_out[7] == 1'b0 && n_out == 1'b0) else $error("shift fill");
    if (is_store && page_adj)
      assert_addr_replace_R10: assert (addr_hi_out == store_data) else $error("addr not replaced");
    if (is_store && !page_adj)
      assert_store_mask_R9: assert (addr_hi_out == addr_hi &&
        (store_data & ~8'(addr_hi + 8'd1)) == 8'h00 && c_out == c_in && z_out == z_in)
        else $error("store mask");
  end
endmodule

bind combo_op_unit combo_op_unit_chk u_chk (.*);

// File: tb/tb_combo_op_unit.sv
module tb_combo_op_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a_in, x_in, y_in, s_in, operand, addr_hi;
  logic c_in, d_in, n_in, z_in, v_in, page_adj;
  logic [7:0] a_out, x_out, s_out, store_data, addr_hi_out;
  logic c_out, n_out, z_out, v_out;

  combo_op_unit dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] a, x, s, st, hi;
    logic c, n, z, v;
  } res_t;

  function automatic string req(input logic [3:0] o, input logic d);
    case (o)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return d ? "R6" : "R5";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9, 4'd10, 4'd11: return page_adj ? "R10" : "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic res_t model();
    res_t r;
    logic [7:0] t, u, hm, src;
    int lo, hs;
    r = '{a: a_in, x: x_in, s: s_in, st: 8'h00, hi: addr_hi,
          c: c_in, n: n_in, z: z_in, v: v_in};
    u = a_in & operand;
    hm = page_adj ? addr_hi : 8'(addr_hi + 1);
    case (op)
      4'd1: begin t = (a_in | 8'hEE) & operand & x_in; r.a = t; r.n = t[7]; r.z = (t == 0); end
      4'd2: begin t = (a_in | 8'hEE) & operand; r.a = t; r.x = t; r.n = t[7]; r.z = (t == 0); end
      4'd3: begin r.a = u; r.c = u[7]; r.n = u[7]; r.z = (u == 0); end
      4'd4: begin t = u >> 1; r.a = t; r.c = u[0]; r.n = 1'b0; r.z = (t == 0); end
      4'd5: begin
        t = {c_in, u[7:1]};
        r.n = t[7]; r.z = (t == 0); r.v = t[6] ^ t[5];
        if (!d_in) begin r.a = t; r.c = t[6]; end
        else begin
          lo = int'(u & 8'h0F) + int'(u[0]);
          if (lo > 5) t = (t & 8'hF0) | ((t + 8'h06) & 8'h0F);
          hs = int'(u & 8'hF0) + int'(u & 8'h10);
          r.c = (hs > 'h50);
          if (r.c) t = t + 8'h60;
          r.a = t;
        end
      end
      4'd6: begin
        t = a_in & x_in;
        r.c = (operand <= t);
        t = t - operand;
        r.x = t; r.n = t[7]; r.z = (t == 0);
      end
      4'd7: begin t = s_in & operand; r.a = t; r.x = t; r.s = t; r.n = t[7]; r.z = (t == 0); end
      4'd8, 4'd9, 4'd10, 4'd11: begin
        src = (op == 4'd9) ? x_in : (op == 4'd10) ? y_in : (a_in & x_in);
        if (op == 4'd11) r.s = a_in & x_in;
        r.st = src & hm;
        if (page_adj) r.hi = r.st;
      end
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk8(input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d actual=%02h expected=%02h", req(op, d_in), nm, op, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [7:0] a, x, y, s, opd, hi,
                       input logic c, d, n, z, v, pa);
    res_t e;
    @(negedge clk);
    op = o; a_in = a; x_in = x; y_in = y; s_in = s; operand = opd; addr_hi = hi;
    c_in = c; d_in = d; n_in = n; z_in = z; v_in = v; page_adj = pa;
    #1;
    e = model();
    chk8("a", a_out, e.a);
    chk8("x", x_out, e.x);
    chk8("s", s_out, e.s);
    chk8("store", store_data, e.st);
    chk8("addr_hi", addr_hi_out, e.hi);
    chk8("flags", {4'b0, c_out, n_out, z_out, v_out}, {4'b0, e.c, e.n, e.z, e.v});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    op = 0; a_in = 0; x_in = 0; y_in = 0; s_in = 0; operand = 0; addr_hi = 0;
    c_in = 0; d_in = 0; n_in = 0; z_in = 0; v_in = 0; page_adj = 0;
    repeat (2) @(posedge clk);
    // R11 idle state and invalid selects
    apply(4'd0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 1, 1, 1, 0, 1, 1);
    apply(4'd15, 8'hFF, 8'h00, 8'hAA, 8'h55, 8'hFF, 8'h10, 0, 0, 0, 1, 0, 0);
    // R1 R2 constant mask
    apply(4'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    apply(4'd2, 8'h11, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    // R3 R4
    apply(4'd3, 8'h80, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    apply(4'd4, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 0, 0, 1, 0, 0, 0);
    // R5 binary rotate, R6 both decimal fix-ups together and alone
    apply(4'd5, 8'hC0, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1, 0, 0, 0, 0, 0);
    apply(4'd5, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1, 1, 0, 0, 0, 0);
    apply(4'd5, 8'h5A, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 1, 0, 0, 1, 0);
    apply(4'd5, 8'h05, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 1, 0, 0, 0, 0);
    apply(4'd5, 8'h60, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1, 1, 0, 0, 0, 0);
    // R7 equal and borrow, carry-in ignored
    apply(4'd6, 8'hF0, 8'h3C, 8'h00, 8'h00, 8'h30, 8'h00, 0, 0, 0, 0, 1, 0);
    apply(4'd6, 8'h0F, 8'h0F, 8'h00, 8'h00, 8'h10, 8'h00, 1, 0, 0, 0, 0, 0);
    // R8
    apply(4'd7, 8'h00, 8'h00, 8'h00, 8'hF3, 8'h3F, 8'h00, 0, 0, 0, 0, 0, 0);
    // R9 high byte wrap, R10 page adjust with stack write
    apply(4'd8, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, 0, 0, 0, 0);
    apply(4'd10, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h12, 0, 0, 0, 0, 0, 0);
    apply(4'd11, 8'hF7, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h3C, 1, 1, 1, 1, 1, 1);
    apply(4'd9, 8'h00, 8'hAA, 8'h00, 8'h00, 8'h00, 8'hF0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2, r3;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      apply(r3[3:0], r1[7:0], r1[15:8], r1[23:16], r1[31:24], r2[7:0], r2[15:8],
            r3[4], r3[5], r3[6], r3[7], r3[8], r3[9]);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule